// File: doc/BRIEF.md
# Staircase Leg Generator with Programmed Switching Angles

This block drives one leg of a seven-level inverter. A free-running phase word, where the full 16-bit range covers one fundamental period, is mapped to a leg level from 0 to 6. The block also produces the four gate signals that select that level. The waveform shape comes from four switching angles that a host computes offline so that chosen low-order harmonics cancel. Inside the first quarter period the level rises three times and then falls once. That quarter is mirrored in time about 90 degrees. The second half period is the first half reflected about the middle level.

The host writes a complete angle set in one strobe. The block checks the ordering and range of the set. It rejects a bad set, raises a flag, and keeps running on the angles it already has. An accepted set waits in a holding register and replaces the running set only when the phase word is exactly zero. The waveform of one period therefore never mixes two sets. A three-phase modulator uses three instances, fed with phase words offset by one third and two thirds of the range.

Top module: `staircase_leg`

## Requirements
- R1: The gate output (bit 3 down to bit 0) encodes the level as 6=1111, 5=1110, 4=1100, 3=1000, 2=0011, 1=0001, 0=0000, and the level never exceeds 6.
- R2: In the first quarter (phase bits 15:14 = 00), the folded position x equals phase[13:0]. The level is 3, plus one for each of the first three angles with x at or above that angle, minus one when x is at or above the fourth angle.
- R3: In the second quarter (bits 15:14 = 01), x = 16384 − phase[13:0]. The waveform is the time mirror of the first quarter about 90 degrees, and phase 16384 gives the same level as a position past the fourth angle.
- R4: In the second half (bit 15 = 1), quarters 10 and 11 fold like 00 and 01. The level is 3 minus the count of R2, so the first half never goes below 3 and the second half never goes above 3.
- R5: The angle word ang_set holds a1 in bits 15:0, a2 in 31:16, a3 in 47:32 and a4 in 63:48. A set is accepted only if a1 ≤ a2 ≤ a3 ≤ a4 < 16384. A rejected write sets cfg_err and leaves both the running set and the held set unchanged. An accepted write clears cfg_err.
- R6: An accepted set becomes the running set only on a cycle in which phase is 0, and that cycle's level already uses it.
- R7: A write accepted in the same cycle as phase 0 is held for the following wrap. The wrap in that cycle uses only a set accepted earlier.
- R8: After reset, and until the first set takes effect, the level is 3 (gate 1000) and cfg_err is 0.
- R9: level, gate and cfg_err reflect the inputs sampled at the previous clock edge.
- R10: With four distinct angles, 0 < a1 and a4 < 16384, one period starting at phase 0 steps through levels 3,4,5,6,5,6,5,4,3,2,1,0,1,0,1,2,3. That is sixteen changes per period, which keeps each device's switching rate low.
- R11: Equal angles merge their steps. With a1 = a2 the level jumps from 3 to 5 at that position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase | input | 16 | Phase word, 65536 = one period |
| ang_wr | input | 1 | Angle set write strobe |
| ang_set | input | 64 | Four packed angles, a1 in the low bits |
| level | output | 3 | Leg level 0..6 |
| gate | output | 4 | Gate pattern for the level |
| cfg_err | output | 1 | Last angle write was rejected |

## Verification
The interesting collision is an angle write that lands in the same cycle as the phase wrap. The swap must then use only a set that was already held, and the new set must wait a full period. The bench provokes this by writing a new set with phase at 0 while nothing is held. It then samples a position where the old and new first angles give different levels, and confirms that the old level persists until the next wrap, where the new set's merged step appears. A second case writes a rejected set with nothing held and then wraps the phase, and checks that the running waveform is left as it was.

// File: rtl/staircase_leg.sv
module staircase_leg #(
  parameter int PW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PW-1:0]   phase,
  input  logic            ang_wr,
  input  logic [4*PW-1:0] ang_set,
  output logic [2:0]      level,
  output logic [3:0]      gate,
  output logic            cfg_err
);
  localparam int QW = PW - 2;
  localparam logic [PW-1:0] QTR = {2'b01, {QW{1'b0}}};

  logic [3:0][PW-1:0] nset, act, pend, eff;
  logic               act_v, pend_v, take, eff_v, set_ok;
  logic [PW-1:0]      low, x;
  logic [1:0]         mag;
  logic [2:0]         nxt_lvl;

  assign nset   = ang_set;
  assign set_ok = (nset[0] <= nset[1]) && (nset[1] <= nset[2]) &&
                  (nset[2] <= nset[3]) && (nset[3] < QTR);
  assign take   = (phase == '0) && pend_v;
  assign eff    = take ? pend : act;
  assign eff_v  = take | act_v;
  assign low    = {2'b00, phase[QW-1:0]};
  assign x      = phase[QW] ? (QTR - low) : low;

  always_comb begin
    mag = 2'd0;
    for (int i = 0; i < 3; i++)
      if (x >= eff[i]) mag = mag + 2'd1;
    if (x >= eff[3]) mag = mag - 2'd1;
  end

  assign nxt_lvl = !eff_v          ? 3'd3 :
                   phase[PW-1]     ? 3'd3 - {1'b0, mag} :
                                     3'd3 + {1'b0, mag};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act     <= '0;
      pend    <= '0;
      act_v   <= 1'b0;
      pend_v  <= 1'b0;
      level   <= 3'd3;
      cfg_err <= 1'b0;
    end else begin
      level <= nxt_lvl;
      if (take) begin
        act    <= pend;
        act_v  <= 1'b1;
        pend_v <= 1'b0;
      end
      if (ang_wr) begin
        if (set_ok) begin
          pend    <= nset;
          pend_v  <= 1'b1;
          cfg_err <= 1'b0;
        end else begin
          cfg_err <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (level)
      3'd6:    gate = 4'b1111;
      3'd5:    gate = 4'b1110;
      3'd4:    gate = 4'b1100;
      3'd3:    gate = 4'b1000;
      3'd2:    gate = 4'b0011;
      3'd1:    gate = 4'b0001;
      default: gate = 4'b0000;
    endcase
  end

  // R1
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= 3'd6);

  // R4
  upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(phase[PW-1]) |-> level >= 3'd3);

  // R4
  lower_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(phase[PW-1]) |-> level <= 3'd3);

  // R5
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ang_wr && !set_ok |=> cfg_err && $stable(pend));

  // R5
  accept_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ang_wr && set_ok |=> !cfg_err);

  // R6
  swap_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act) |-> $past(phase) == '0);
endmodule

// File: tb/staircase_leg_test.sv
module staircase_leg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] phase = '0;
  logic        ang_wr = 1'b0;
  logic [63:0] ang_set = '0;
  logic [2:0]  level;
  logic [3:0]  gate;
  logic        cfg_err;

  always #2 clk = ~clk;

  staircase_leg uut (.clk(clk), .rst_n(rst_n), .phase(phase), .ang_wr(ang_wr),
                     .ang_set(ang_set), .level(level), .gate(gate), .cfg_err(cfg_err));

  typedef struct packed { logic [2:0] lv; logic [3:0] g; logic e; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  int    n_cmp = 0, n_bad = 0;
  int    seq[$];
  int    prevlv = 3;

  logic [15:0] m_act[4], m_pend[4];
  bit m_av = 0, m_pv = 0, m_err = 0;

  function automatic logic [3:0] gate_of(input logic [2:0] l);
    case (l)
      3'd6: return 4'b1111;  3'd5: return 4'b1110;  3'd4: return 4'b1100;
      3'd3: return 4'b1000;  3'd2: return 4'b0011;  3'd1: return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [63:0] pk(input int a1, input int a2, input int a3, input int a4);
    return {16'(a4), 16'(a3), 16'(a2), 16'(a1)};
  endfunction

  function automatic bit ok_of(input logic [63:0] s);
    return s[15:0] <= s[31:16] && s[31:16] <= s[47:32] &&
           s[47:32] <= s[63:48] && s[63:48] < 16'd16384;
  endfunction

  function automatic logic [2:0] model_level(input int p, input logic [15:0] e[4], input bit v);
    int q, lo, x, m;
    if (!v) return 3'd3;
    q  = p >> 14;
    lo = p & 16'h3FFF;
    x  = (q % 2 == 1) ? 16384 - lo : lo;
    m  = 0;
    for (int i = 0; i < 3; i++) if (x >= int'(e[i])) m++;
    if (x >= int'(e[3])) m--;
    return 3'((q >= 2) ? 3 - m : 3 + m);
  endfunction

  task automatic step(input int p, input string tag, input bit wr = 1'b0, input logic [63:0] s = '0);
    logic [15:0] e[4];
    bit ev;
    logic [2:0] lv;
    @(negedge clk);
    phase = 16'(p); ang_wr = wr; ang_set = s;
    if (p == 0 && m_pv) begin e = m_pend; ev = 1; end
    else begin e = m_act; ev = m_av; end
    lv = model_level(p, e, ev);
    if (p == 0 && m_pv) begin m_act = m_pend; m_av = 1; m_pv = 0; end
    if (wr) begin
      if (ok_of(s)) begin
        for (int i = 0; i < 4; i++) m_pend[i] = s[16*i +: 16];
        m_pv = 1; m_err = 0;
      end else m_err = 1;
    end
    exp_q.push_back({lv, gate_of(lv), m_err});
    tag_q.push_back(tag);
  endtask

  task automatic sweep(input int start, input int stp, input int n, input string tag);
    for (int i = 0; i < n; i++) step((start + i * stp) % 65536, tag);
  endtask

  // Monitor: one-cycle latency (R9), gate encoding compared on every item (R1)
  always begin
    exp_t  ex;
    string tg;
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      ex = exp_q.pop_front();
      tg = tag_q.pop_front();
      n_cmp++;
      if (level !== ex.lv) begin
        n_bad++;
        $display("FAIL %s R9 level act=%0d exp=%0d", tg, level, ex.lv);
      end else if (gate !== ex.g) begin
        n_bad++;
        $display("FAIL R1 gate act=%b exp=%b", gate, ex.g);
      end else if (cfg_err !== ex.e) begin
        n_bad++;
        $display("FAIL R5 cfg_err act=%0b exp=%0b", cfg_err, ex.e);
      end
      if (tg == "R10" && int'(level) != prevlv) begin
        seq.push_back(int'(level));
        prevlv = int'(level);
      end
    end
  end

  task automatic chk(input bit c, input string msg, input int act, input int expv);
    n_cmp++;
    if (!c) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", msg, act, expv);
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_act[i] = '0; m_pend[i] = '0; end
    #40000;
    n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", n_cmp, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int want[16] = '{4,5,6,5,6,5,4,3,2,1,0,1,0,1,2,3};
    bit same;
    repeat (4) @(posedge clk);
    #1;
    chk(level == 3'd3, "R8 reset level", level, 3);
    chk(gate == 4'b1000, "R8 reset gate", gate, 8);
    chk(cfg_err == 1'b0, "R8 reset err", cfg_err, 0);
    @(negedge clk);
    rst_n = 1'b1;

    step(16'h1000, "R8"); step(16'hC000, "R8"); step(0, "R8");
    step(16'h2000, "R6", 1, pk(1820, 3641, 6372, 10923));
    step(16'h5000, "R6");

    sweep(0, 128, 512, "R10");

    step(1819, "R2"); step(1820, "R2"); step(3641, "R2"); step(10922, "R2"); step(10923, "R2");
    step(16384, "R3"); step(14564, "R3"); step(14565, "R3"); step(16384 + 5000, "R3");
    step(32768, "R4"); step(32768 + 3641, "R4"); step(49152, "R4"); step(65535, "R4");

    step(5000, "R5", 1, pk(3641, 1820, 6372, 10923));
    step(7000, "R5");
    step(5000, "R5", 1, pk(1, 2, 3, 16384));
    step(0, "R5"); step(3641, "R5"); step(40000, "R5");
    step(20000, "R5", 1, pk(2000, 5000, 9000, 14000));
    sweep(20256, 256, 177, "R6");
    step(0, "R6"); step(5000, "R6"); step(15000, "R6");

    step(16'h8000, "R7");
    step(0, "R7", 1, pk(3000, 3000, 8000, 12000));
    step(2500, "R7"); step(33000, "R7");
    step(0, "R7");
    step(2999, "R11"); step(3000, "R11"); step(8000, "R11"); step(12000, "R11");
    step(32768 + 3000, "R11");

    @(negedge clk);
    ang_wr = 1'b0;
    repeat (3) @(negedge clk);

    same = (seq.size() == 16);
    if (same) for (int i = 0; i < 16; i++) if (seq[i] != want[i]) same = 0;
    chk(same, "R10 transition order, count", seq.size(), 16);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule